// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block is a small register bank that controls and monitors a USB 2.0 PHY port. Software reaches it over a plain 32-bit register bus. Every write is bit-masked: the upper halfword of the write data is a per-bit write enable for the lower halfword. A driver can therefore change one field, such as the operating mode, the suspend code or one analog charger-detection enable, without first reading the register back.

The bank drives the PHY's control fields: a 9-bit suspend code, a 4-bit operating mode, six charger-detection analog enables and an ID override. It also watches the PHY's live signals (VBUS-valid, ID, line state and the charger comparator outputs). Each of these passes through a synchronizer. Four sticky event detectors fire on a VBUS-valid rise, an ID rise, an ID fall and a line-state change. Each detector has an enable and a status bit. The status bit is cleared by a masked write of 1. A single interrupt output combines all enabled pending events.

Read data follows the word address combinationally. The address is a word index: 0 is control, 1 is analog, 2 is events, 3 is live status. All other indexes are unmapped.

Top module: `phy_ctl_regbank`

## Requirements
- R1: A write to a mapped register updates lower bit i only when wdata bit i+16 is 1; every other bit keeps its value, and reserved bits (control bit 11, analog bits 15:6, event bits 15:8) always read 0.
- R2: After reset, control reads 0x5000 (suspend code 0, ID override off, operating mode 5 = non-driving), and analog, event enables, event status and irq_o are all 0.
- R3: Control word 0 holds suspend [8:0] (active code 0x1d1) driving suspend_o, and operating mode [15:12] (1 = normal) driving opmode_o. Analog word 1 holds [0] DP voltage source, [1] DM voltage source, [2] DM current sink, [3] DP current sink, [4] DP current source, [5] DM pull-down, each driving its enable output.
- R4: With control bit 9 set, id_o equals control bit 10; with bit 9 clear, id_o equals the synchronized ID input.
- R5: Status word 3 reads the synchronized inputs ([0] VBUS-valid, [1] ID, [3:2] line state, [4] primary comparator, [5] secondary comparator, [6] data contact) two clocks after they change; writes to it have no effect.
- R6: Event word 2 holds the enable of event k at bit 2k and its status at bit 2k+1, for k = 0 VBUS-valid rise, 1 ID rise, 2 ID fall, 3 line-state change. An enabled event's status bit reads 1 three clocks after its input changes.
- R7: A status bit whose enable is 0 does not set on its edge.
- R8: A set status bit stays 1 until a write with both its data bit and mask bit at 1. A data-only or mask-only write leaves it set.
- R9: When an edge sets a status bit in the same cycle that a write clears it, the bit ends at 1.
- R10: irq_o is 1 exactly when some event has both its status and its enable at 1. Clearing an enable drops irq_o while the status bit stays set.
- R11: Word addresses 4 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1 |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data: [31:16] bit mask, [15:0] value |
| rdata_o | output | 32 | Read data for addr_i |
| vbus_valid_i | input | 1 | PHY VBUS-valid, asynchronous |
| id_i | input | 1 | PHY ID pin level, asynchronous |
| linestate_i | input | 2 | PHY line state, asynchronous |
| chg_cp_i | input | 1 | Primary charger comparator |
| chg_dcp_i | input | 1 | Secondary charger comparator |
| chg_dcd_i | input | 1 | Data contact comparator |
| suspend_o | output | 9 | Suspend code to PHY |
| opmode_o | output | 4 | Operating mode to PHY |
| dp_vsrc_en_o | output | 1 | DP voltage source enable |
| dm_vsrc_en_o | output | 1 | DM voltage source enable |
| dm_isink_en_o | output | 1 | DM current sink enable |
| dp_isink_en_o | output | 1 | DP current sink enable |
| dp_isrc_en_o | output | 1 | DP current source enable |
| dm_pulldn_en_o | output | 1 | DM pull-down enable |
| id_o | output | 1 | ID seen by the controller |
| irq_o | output | 1 | Any enabled event pending |

## Verification
The assertions check the following on every cycle:
- the control word stays unchanged without a masked write;
- a status bit never sets while its enable is off;
- an enabled edge always sets its status bit, even against a clear;
- a pending status survives anything but a full clear;
- the ID override wins over the PHY;
- unmapped reads return zero.

Only the bench's scenarios can show some behaviours. These are the exact three-clock latency from pin to status and the two-clock latency into the status word. They also include reset values, the field positions behind each output, and the interrupt dropping when an enable is cleared while its status stays set. A random phase compared against the reference model mixes masked writes with toggling inputs.

// File: rtl/phy_rb_pkg.sv
package phy_rb_pkg;
  localparam int NUM_EVT = 4;
  localparam int EVT_VBUS_RISE = 0;
  localparam int EVT_ID_RISE   = 1;
  localparam int EVT_ID_FALL   = 2;
  localparam int EVT_LS_CHG    = 3;

  localparam int SUSP_W    = 9;
  localparam int OPM_W     = 4;
  localparam int ANA_W     = 6;
  localparam int IDSEL_BIT = 9;
  localparam int IDVAL_BIT = 10;
  localparam int OPM_LSB   = 12;

  localparam logic [SUSP_W-1:0] SUSP_OFF  = 9'h000;
  localparam logic [SUSP_W-1:0] SUSP_ON   = 9'h1d1;
  localparam logic [OPM_W-1:0]  OPM_NODRV = 4'd5;
  localparam logic [OPM_W-1:0]  OPM_NORM  = 4'd1;

  localparam logic [15:0] CTRL_WMASK = 16'hF7FF;
  localparam logic [15:0] CTRL_RST   = {OPM_NODRV, 3'b000, SUSP_OFF};
  localparam logic [15:0] ANA_WMASK  = 16'((1 << ANA_W) - 1);

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_ANA  = 2'd1,
    A_EVT  = 2'd2,
    A_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       dcd;
    logic       dcp;
    logic       cp;
    logic [1:0] ls;
    logic       id;
    logic       vbus;
  } phy_in_t;

  // lower half takes new data where the upper-half enable is set
  function automatic logic [15:0] mask_merge(logic [15:0] old_v, logic [31:0] wd,
                                             logic [15:0] legal);
    logic [15:0] en;
    en = wd[31:16] & legal;
    return (old_v & ~en) | (wd[15:0] & en);
  endfunction
endpackage

// File: rtl/phy_rb_sync.sv
module phy_rb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/phy_rb_edge.sv
module phy_rb_edge import phy_rb_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vbus_i,
  input  logic               id_i,
  input  logic [1:0]         ls_i,
  output logic [NUM_EVT-1:0] edge_o
);
  logic       vbus_q, id_q;
  logic [1:0] ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbus_q <= 1'b0;
      id_q   <= 1'b0;
      ls_q   <= '0;
    end else begin
      vbus_q <= vbus_i;
      id_q   <= id_i;
      ls_q   <= ls_i;
    end
  end

  assign edge_o[EVT_VBUS_RISE] = vbus_i & ~vbus_q;
  assign edge_o[EVT_ID_RISE]   = id_i & ~id_q;
  assign edge_o[EVT_ID_FALL]   = ~id_i & id_q;
  assign edge_o[EVT_LS_CHG]    = ls_i != ls_q;
endmodule

// File: rtl/phy_rb_evt_slot.sv
module phy_rb_evt_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic en_we_i,
  input  logic en_d_i,
  input  logic clr_i,
  output logic en_o,
  output logic st_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      st_o <= 1'b0;
    end else begin
      if (en_we_i) en_o <= en_d_i;
      // a qualifying edge beats a simultaneous clear
      if (edge_i && en_o) st_o <= 1'b1;
      else if (clr_i)     st_o <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank import phy_rb_pkg::*; #(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              vbus_valid_i,
  input  logic              id_i,
  input  logic [1:0]        linestate_i,
  input  logic              chg_cp_i,
  input  logic              chg_dcp_i,
  input  logic              chg_dcd_i,
  output logic [8:0]        suspend_o,
  output logic [3:0]        opmode_o,
  output logic              dp_vsrc_en_o,
  output logic              dm_vsrc_en_o,
  output logic              dm_isink_en_o,
  output logic              dp_isink_en_o,
  output logic              dp_isrc_en_o,
  output logic              dm_pulldn_en_o,
  output logic              id_o,
  output logic              irq_o
);
  localparam int SEL_W = 2;
  localparam int PIN_W = $bits(phy_in_t);

  logic     hit, wr;
  reg_sel_e sel;
  phy_in_t  pin_raw, pin_s;

  logic [15:0]      ctrl_q;
  logic [ANA_W-1:0] ana_q;
  logic [NUM_EVT-1:0] evt_en, evt_st, evt_edge;
  logic [15:0]      evt_rd;

  assign hit = (addr_i >> SEL_W) == '0;
  assign sel = reg_sel_e'(addr_i[SEL_W-1:0]);
  assign wr  = req_i & we_i & hit;

  assign pin_raw = {chg_dcd_i, chg_dcp_i, chg_cp_i, linestate_i, id_i, vbus_valid_i};

  phy_rb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      ana_q  <= '0;
    end else if (wr) begin
      if (sel == A_CTRL) ctrl_q <= mask_merge(ctrl_q, wdata_i, CTRL_WMASK);
      if (sel == A_ANA)  ana_q  <= ANA_W'(mask_merge(16'(ana_q), wdata_i, ANA_WMASK));
    end
  end

  phy_rb_edge i_edge (
    .clk_i, .rst_ni,
    .vbus_i(pin_s.vbus), .id_i(pin_s.id), .ls_i(pin_s.ls),
    .edge_o(evt_edge)
  );

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    logic wr_evt;
    assign wr_evt = wr && (sel == A_EVT);
    phy_rb_evt_slot i_slot (
      .clk_i, .rst_ni,
      .edge_i (evt_edge[k]),
      .en_we_i(wr_evt && wdata_i[16+2*k]),
      .en_d_i (wdata_i[2*k]),
      .clr_i  (wr_evt && wdata_i[17+2*k] && wdata_i[2*k+1]),
      .en_o   (evt_en[k]),
      .st_o   (evt_st[k])
    );
  end

  always_comb begin
    evt_rd = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      evt_rd[2*k]   = evt_en[k];
      evt_rd[2*k+1] = evt_st[k];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (sel)
        A_CTRL:  rdata_o = {16'h0, ctrl_q};
        A_ANA:   rdata_o = 32'(ana_q);
        A_EVT:   rdata_o = {16'h0, evt_rd};
        default: rdata_o = 32'(pin_s);
      endcase
    end
  end

  assign suspend_o      = ctrl_q[SUSP_W-1:0];
  assign opmode_o       = ctrl_q[OPM_LSB +: OPM_W];
  assign dp_vsrc_en_o   = ana_q[0];
  assign dm_vsrc_en_o   = ana_q[1];
  assign dm_isink_en_o  = ana_q[2];
  assign dp_isink_en_o  = ana_q[3];
  assign dp_isrc_en_o   = ana_q[4];
  assign dm_pulldn_en_o = ana_q[5];
  assign id_o           = ctrl_q[IDSEL_BIT] ? ctrl_q[IDVAL_BIT] : pin_s.id;
  assign irq_o          = |(evt_en & evt_st);
endmodule

// File: rtl/phy_rb_chk.sv
module phy_rb_chk import phy_rb_pkg::*; #(
  parameter int ADDR_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic               id_o,
  input logic               irq_o,
  input logic [15:0]        ctrl_q,
  input logic [NUM_EVT-1:0] evt_en,
  input logic [NUM_EVT-1:0] evt_st,
  input logic [NUM_EVT-1:0] evt_edge
);
  logic wr_ctrl, wr_evt;
  assign wr_ctrl = req_i && we_i && (addr_i == ADDR_W'(0)) && (wdata_i[31:16] != '0);
  assign wr_evt  = req_i && we_i && (addr_i == ADDR_W'(2));

  a_r1_no_mask_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q));

  a_r4_id_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[IDSEL_BIT] |-> (id_o == ctrl_q[IDVAL_BIT]));

  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_W'(4)) |-> (rdata_o == '0));

  a_r10_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (evt_st != '0));

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_k
    logic clr_k;
    assign clr_k = wr_evt && wdata_i[17+2*k] && wdata_i[2*k+1];

    a_r7_off_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_en[k] && !evt_st[k]) |=> !evt_st[k]);

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_edge[k] && evt_en[k]) |=> evt_st[k]);

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_st[k] && !clr_k) |=> evt_st[k]);
  end
endmodule

bind phy_ctl_regbank phy_rb_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .id_o, .irq_o,
  .ctrl_q, .evt_en, .evt_st, .evt_edge
);

// File: tb/test_phy_ctl_regbank.sv
module test_phy_ctl_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [6:0]  pin = '0;   // [0] vbus [1] id [3:2] ls [4] cp [5] dcp [6] dcd
  logic [31:0] rdata;
  logic [8:0]  suspend;
  logic [3:0]  opmode;
  logic dp_vsrc, dm_vsrc, dm_isink, dp_isink, dp_isrc, dm_pulldn, id_out, irq;

  phy_ctl_regbank i_phy_ctl_regbank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .vbus_valid_i(pin[0]), .id_i(pin[1]), .linestate_i(pin[3:2]),
    .chg_cp_i(pin[4]), .chg_dcp_i(pin[5]), .chg_dcd_i(pin[6]),
    .suspend_o(suspend), .opmode_o(opmode),
    .dp_vsrc_en_o(dp_vsrc), .dm_vsrc_en_o(dm_vsrc), .dm_isink_en_o(dm_isink),
    .dp_isink_en_o(dp_isink), .dp_isrc_en_o(dp_isrc), .dm_pulldn_en_o(dm_pulldn),
    .id_o(id_out), .irq_o(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_ctrl = 16'h5000;
  logic [15:0] m_ana  = '0;
  logic [3:0]  m_en = '0, m_st = '0;
  logic [6:0]  hist[$] = '{7'h0, 7'h0, 7'h0};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rd(logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v = {16'h0, m_ctrl};
      3'd1: v = {16'h0, m_ana};
      3'd2: for (int k = 0; k < 4; k++) begin
              v[2*k] = m_en[k];
              v[2*k+1] = m_st[k];
            end
      3'd3: v = 32'(hist[1]);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic compare_all();
    string t;
    case (addr)
      3'd0, 3'd1: t = "R1 read data";
      3'd2:       t = "R8 event word";
      3'd3:       t = "R5 status word";
      default:    t = "R11 unmapped read";
    endcase
    chk(t, rdata, m_rd(addr));
    chk("R3 suspend_o", 32'(suspend), 32'(m_ctrl[8:0]));
    chk("R3 opmode_o", 32'(opmode), 32'(m_ctrl[15:12]));
    chk("R3 analog enables",
        32'({dm_pulldn, dp_isrc, dp_isink, dm_isink, dm_vsrc, dp_vsrc}), 32'(m_ana[5:0]));
    chk("R4 id_o", 32'(id_out), 32'(m_ctrl[9] ? m_ctrl[10] : hist[1][1]));
    chk("R10 irq_o", 32'(irq), 32'(|(m_en & m_st)));
  endtask

  task automatic model_clock();
    logic [6:0] h1, h2;
    logic [3:0] e;
    logic [15:0] mk, dt;
    logic wr;
    h1 = hist[1]; h2 = hist[2];
    e[0] = h1[0] & ~h2[0];
    e[1] = h1[1] & ~h2[1];
    e[2] = ~h1[1] & h2[1];
    e[3] = h1[3:2] != h2[3:2];
    wr = req && we && (addr < 3'd4);
    mk = wdata[31:16]; dt = wdata[15:0];
    if (wr && addr == 3'd0) m_ctrl = (m_ctrl & ~(mk & 16'hF7FF)) | (dt & mk & 16'hF7FF);
    if (wr && addr == 3'd1) m_ana  = (m_ana & ~(mk & 16'h003F)) | (dt & mk & 16'h003F);
    for (int k = 0; k < 4; k++) begin
      logic old_en;
      old_en = m_en[k];
      if (wr && addr == 3'd2 && mk[2*k]) m_en[k] = dt[2*k];
      if (e[k] && old_en) m_st[k] = 1'b1;
      else if (wr && addr == 3'd2 && mk[2*k+1] && dt[2*k+1]) m_st[k] = 1'b0;
    end
    hist.push_front(pin);
    void'(hist.pop_back());
  endtask

  task automatic finish_cycle();
    compare_all();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic step(logic r, logic w, logic [2:0] a, logic [31:0] d);
    req = r; we = w; addr = a; wdata = d;
    #1;
    finish_cycle();
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    req = 1; we = 0; addr = a; wdata = '0;
    #1;
    chk(tag, rdata, exp);
    finish_cycle();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset values
    #1;
    chk("R2 suspend reset", 32'(suspend), 32'h0);
    chk("R2 opmode reset", 32'(opmode), 32'h5);
    chk("R2 irq reset", 32'(irq), 32'h0);
    rd_chk("R2 control reset", 3'd0, 32'h5000);
    rd_chk("R2 analog reset", 3'd1, 32'h0);
    rd_chk("R2 event reset", 3'd2, 32'h0);

    // R1 masked writes, R3 field placement
    step(1, 1, 3'd0, 32'h01FF_01D1);
    rd_chk("R1 suspend field write", 3'd0, 32'h51D1);
    chk("R3 suspend active code", 32'(suspend), 32'h1D1);
    step(1, 1, 3'd0, 32'hF000_1000);
    rd_chk("R1 opmode only", 3'd0, 32'h11D1);
    chk("R3 opmode normal", 32'(opmode), 32'h1);
    step(1, 1, 3'd0, 32'h0000_FFFF);
    rd_chk("R1 zero mask ignored", 3'd0, 32'h11D1);
    step(1, 1, 3'd0, 32'h0800_0800);
    rd_chk("R1 reserved bit 11", 3'd0, 32'h11D1);
    step(1, 1, 3'd0, 32'h0001_0000);
    rd_chk("R1 single bit clear", 3'd0, 32'h11D0);
    step(1, 1, 3'd1, 32'hFFD5_FFD5);
    rd_chk("R1 analog reserved", 3'd1, 32'h0015);
    chk("R3 DP vsrc", 32'(dp_vsrc), 32'h1);
    chk("R3 DP isrc", 32'(dp_isrc), 32'h1);
    step(1, 1, 3'd1, 32'h0004_0000);
    rd_chk("R3 analog bit 2 clear", 3'd1, 32'h0011);
    chk("R3 DM isink off", 32'(dm_isink), 32'h0);

    // R4 ID override
    pin[1] = 1'b1; idle(3);
    #1; chk("R4 id follows phy", 32'(id_out), 32'h1); @(negedge clk);
    step(1, 1, 3'd0, 32'h0600_0200);
    #1; chk("R4 override low", 32'(id_out), 32'h0); @(negedge clk);
    pin[1] = 1'b0; idle(3);
    step(1, 1, 3'd0, 32'h0600_0600);
    #1; chk("R4 override high", 32'(id_out), 32'h1); @(negedge clk);
    step(1, 1, 3'd0, 32'h0200_0000);
    #1; chk("R4 release override", 32'(id_out), 32'h0); @(negedge clk);

    // R11 unmapped
    step(1, 1, 3'd5, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped read", 3'd5, 32'h0);
    rd_chk("R11 write had no effect", 3'd0, 32'h15D0);

    // R6 events
    step(1, 1, 3'd2, 32'h0055_0055);
    rd_chk("R6 enables set", 3'd2, 32'h0055);
    pin[0] = 1'b1; idle(2);
    rd_chk("R6 not yet set", 3'd2, 32'h0055);
    rd_chk("R6 vbus rise set", 3'd2, 32'h0057);
    #1; chk("R10 irq pending", 32'(irq), 32'h1); @(negedge clk);
    step(1, 1, 3'd2, 32'h0000_0002);
    rd_chk("R8 data-only write keeps", 3'd2, 32'h0057);
    step(1, 1, 3'd2, 32'h0002_0000);
    rd_chk("R8 mask-only write keeps", 3'd2, 32'h0057);
    step(1, 1, 3'd2, 32'h0001_0000);
    rd_chk("R10 status kept, enable off", 3'd2, 32'h0056);
    #1; chk("R10 irq off with enable", 32'(irq), 32'h0); @(negedge clk);
    step(1, 1, 3'd2, 32'h0001_0001);
    #1; chk("R10 irq back on", 32'(irq), 32'h1); @(negedge clk);
    step(1, 1, 3'd2, 32'h0002_0002);
    rd_chk("R8 full clear", 3'd2, 32'h0055);

    // R7 disabled event does not set
    step(1, 1, 3'd2, 32'h0001_0000);
    pin[0] = 1'b0; idle(3);
    pin[0] = 1'b1; idle(3);
    rd_chk("R7 disabled rise ignored", 3'd2, 32'h0054);
    step(1, 1, 3'd2, 32'h0001_0001);

    // ID rise then R9 collision on ID fall
    pin[1] = 1'b1; idle(3);
    rd_chk("R6 id rise set", 3'd2, 32'h005D);
    step(1, 1, 3'd2, 32'h0008_0008);
    pin[1] = 1'b0; idle(2);
    step(1, 1, 3'd2, 32'h0020_0020);
    rd_chk("R9 set beats clear", 3'd2, 32'h0075);
    step(1, 1, 3'd2, 32'h0020_0020);
    rd_chk("R8 id fall cleared", 3'd2, 32'h0055);

    // line-state change and R5 status word
    pin[3:2] = 2'b10; pin[4] = 1'b1; pin[6] = 1'b1; idle(3);
    rd_chk("R6 line state change", 3'd2, 32'h00D5);
    step(1, 1, 3'd3, 32'hFFFF_0000);
    rd_chk("R5 status ignores writes", 3'd3, 32'h0059);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      if ((i % 3) == 0) pin = 7'($urandom);
      step(1'($urandom), 1'($urandom), 3'($urandom), $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule